// File: doc/BRIEF.md
# Little-Endian Load/Store Lane Aligner

This block sits between a word-wide memory data bus and the processor's load/store datapath. Memory always delivers and accepts a whole word. The processor works with byte, halfword and word accesses at any byte address.

On the load side, the addressed byte or halfword is shifted right into the least significant lanes, so that the processor can sign- or zero-extend the low-order bits itself. Lanes are numbered little-endian: offset 00 is the least significant byte. On the store side, the low byte or halfword of the processor's write data is copied into the lane(s) that the offset selects, and a per-lane write-enable mask goes with it. A byte store enables one lane. A halfword store enables the lower or the upper lane pair. Accesses whose offset does not fit the access size raise a flag; apart from the flag, they are handled as the aligned access that the dropped address bits imply.

A parameter chooses whether the outputs are registered (one clock of latency) or combinational.

Top module: `lane_align_unit`

## Requirements
- R1: The size code is 2'b00 for byte, 2'b01 for halfword and 2'b10 for word. Code 2'b11 is handled exactly as word.
- R2: A word load drives `ld_result` with all 32 bits of `rd_word`, unshifted, for every offset.
- R3: For a halfword load, `ld_result[15:0]` is `rd_word[31:16]` when offset bit 1 is 1, and `rd_word[15:0]` when it is 0. `ld_result[31:16]` is zero.
- R4: For a byte load at offset k, `ld_result[7:0]` is `rd_word[8k+7:8k]` and `ld_result[31:8]` is zero.
- R5: A halfword store drives `wr_lanes` as `{wr_src[15:0], wr_src[15:0]}`. `wr_be` is 4'b0011 when offset bit 1 is 0 and 4'b1100 when it is 1.
- R6: A byte store places `wr_src[7:0]` in all four lanes of `wr_lanes`. `wr_be` has only bit k set, for offset k.
- R7: A word store drives `wr_lanes` with `wr_src` unchanged and `wr_be` with 4'b1111.
- R8: `misalign` is 1 for a halfword access with offset bit 0 set, and for a word access with a nonzero offset. It is 0 for every byte access. A flagged access behaves like the aligned access in which the offending offset bits are taken as zero.
- R9: With OUT_REG=1, every output follows its inputs one clock later and is zero while `rst_n` is low. With OUT_REG=0, every output follows its inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used when OUT_REG=1) |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| acc_size | input | 2 | Access size code (R1) |
| byte_off | input | 2 | Byte address bits 1:0 |
| rd_word | input | 32 | Word read from memory |
| wr_src | input | 32 | Processor store data, right-aligned |
| ld_result | output | 32 | Load data shifted into the low lanes |
| wr_lanes | output | 32 | Store data placed in the memory lanes |
| wr_be | output | 4 | Per-lane write enable, bit k for byte lane k |
| misalign | output | 1 | Offset does not fit the access size |

## Verification
The bench builds two copies of the block side by side, one with OUT_REG=1 and one with OUT_REG=0, and keeps the default 32-bit data width and 8-bit lanes. The registered copy brings the reset clearing and the one-cycle latency within reach. The combinational copy checks the same shifting and lane placement with no pipeline in between. Both are driven through every size code and offset, including the reserved size code and all misaligned combinations, and then with pseudo-random traffic.

// File: rtl/lane_align_pkg.sv
package lane_align_pkg;

  typedef enum logic [1:0] {
    ACC_BYTE = 2'b00,
    ACC_HALF = 2'b01,
    ACC_WORD = 2'b10,
    ACC_RSVD = 2'b11
  } acc_size_e;

  // Number of lanes an access of the given size covers.
  function automatic int unsigned lanes_of(input acc_size_e sz, input int unsigned nlanes);
    case (sz)
      ACC_BYTE: lanes_of = 1;
      ACC_HALF: lanes_of = nlanes / 2;
      default:  lanes_of = nlanes;
    endcase
  endfunction

endpackage

// File: rtl/la_align_check.sv
module la_align_check
  import lane_align_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  acc_size_e          size,
  input  logic [OFF_W-1:0]   off_in,
  output logic [OFF_W-1:0]   off_eff,
  output logic               bad_align
);

  // Low offset bits that must be zero for an access of this size.
  logic [OFF_W-1:0] must_zero;

  always_comb begin
    case (size)
      ACC_BYTE: must_zero = '0;
      ACC_HALF: must_zero = {{(OFF_W-1){1'b0}}, 1'b1};
      default:  must_zero = '1;
    endcase
    bad_align = |(off_in & must_zero);
    off_eff   = off_in & ~must_zero;
  end

endmodule

// File: rtl/la_load_lanes.sv
module la_load_lanes
  import lane_align_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int NLANES = DATA_W / LANE_W,
  localparam int OFF_W = $clog2(NLANES)
) (
  input  acc_size_e          size,
  input  logic [OFF_W-1:0]   off,
  input  logic [DATA_W-1:0]  word_in,
  output logic [DATA_W-1:0]  word_out
);

  // Move `count` lanes starting at lane `first` down to lane 0; the rest is zero.
  function automatic logic [DATA_W-1:0] pick_lanes(
    input logic [DATA_W-1:0] w,
    input int unsigned       first,
    input int unsigned       count
  );
    logic [DATA_W-1:0] r;
    r = '0;
    for (int i = 0; i < NLANES; i++) begin
      if (i < count && (first + i) < NLANES)
        r[i*LANE_W +: LANE_W] = w[(first + i)*LANE_W +: LANE_W];
    end
    return r;
  endfunction

  always_comb begin
    word_out = pick_lanes(word_in, int'(off), lanes_of(size, NLANES));
  end

endmodule

// File: rtl/la_store_lanes.sv
module la_store_lanes
  import lane_align_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int NLANES = DATA_W / LANE_W,
  localparam int OFF_W = $clog2(NLANES)
) (
  input  acc_size_e          size,
  input  logic [OFF_W-1:0]   off,
  input  logic [DATA_W-1:0]  src,
  output logic [DATA_W-1:0]  lanes,
  output logic [NLANES-1:0]  be
);

  // Repeat the low `count` lanes of the source across the whole word.
  function automatic logic [DATA_W-1:0] spread(
    input logic [DATA_W-1:0] s,
    input int unsigned       count
  );
    logic [DATA_W-1:0] r;
    for (int i = 0; i < NLANES; i++)
      r[i*LANE_W +: LANE_W] = s[(i % count)*LANE_W +: LANE_W];
    return r;
  endfunction

  // Enable `count` lanes starting at lane `first`.
  function automatic logic [NLANES-1:0] enables(
    input int unsigned first,
    input int unsigned count
  );
    logic [NLANES-1:0] r;
    for (int i = 0; i < NLANES; i++)
      r[i] = (i >= first) && (i < first + count);
    return r;
  endfunction

  always_comb begin
    lanes = spread(src, lanes_of(size, NLANES));
    be    = enables(int'(off), lanes_of(size, NLANES));
  end

endmodule

// File: rtl/lane_align_unit.sv
module lane_align_unit
  import lane_align_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int LANE_W  = 8,
  parameter bit OUT_REG = 1'b1,
  localparam int NLANES = DATA_W / LANE_W,
  localparam int OFF_W  = $clog2(NLANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        acc_size,
  input  logic [OFF_W-1:0]  byte_off,
  input  logic [DATA_W-1:0] rd_word,
  input  logic [DATA_W-1:0] wr_src,
  output logic [DATA_W-1:0] ld_result,
  output logic [DATA_W-1:0] wr_lanes,
  output logic [NLANES-1:0] wr_be,
  output logic              misalign
);

  acc_size_e         size_c;
  logic [OFF_W-1:0]  off_eff;
  logic              misalign_c;
  logic [DATA_W-1:0] ld_c;
  logic [DATA_W-1:0] wr_lanes_c;
  logic [NLANES-1:0] wr_be_c;

  assign size_c = acc_size_e'(acc_size);

  la_align_check #(.OFF_W(OFF_W)) u_check (
    .size      (size_c),
    .off_in    (byte_off),
    .off_eff   (off_eff),
    .bad_align (misalign_c)
  );

  la_load_lanes #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_load (
    .size     (size_c),
    .off      (off_eff),
    .word_in  (rd_word),
    .word_out (ld_c)
  );

  la_store_lanes #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_store (
    .size  (size_c),
    .off   (off_eff),
    .src   (wr_src),
    .lanes (wr_lanes_c),
    .be    (wr_be_c)
  );

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          ld_result <= '0;
          wr_lanes  <= '0;
          wr_be     <= '0;
          misalign  <= 1'b0;
        end else begin
          ld_result <= ld_c;
          wr_lanes  <= wr_lanes_c;
          wr_be     <= wr_be_c;
          misalign  <= misalign_c;
        end
      end

      AST_REG_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (size_c == ACC_WORD) |=> (ld_result == $past(rd_word))) else $error("R9"); // R9
    end else begin : g_comb
      assign ld_result = ld_c;
      assign wr_lanes  = wr_lanes_c;
      assign wr_be     = wr_be_c;
      assign misalign  = misalign_c;
    end
  endgenerate

  // Checks on the internal, pre-register results, valid for both variants.
  AST_WORD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (size_c == ACC_WORD || size_c == ACC_RSVD) |-> (ld_c == rd_word)) else $error("R2"); // R2
  AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (size_c == ACC_HALF) |-> (ld_c[DATA_W-1:DATA_W/2] == '0)) else $error("R3"); // R3
  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (size_c == ACC_BYTE) |-> (ld_c[DATA_W-1:LANE_W] == '0)) else $error("R4"); // R4
  AST_HALF_BE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (size_c == ACC_HALF) |-> ($countones(wr_be_c) == NLANES/2)) else $error("R5"); // R5
  AST_BYTE_BE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (size_c == ACC_BYTE) |-> ($countones(wr_be_c) == 1)) else $error("R6"); // R6
  AST_WORD_BE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (size_c == ACC_WORD) |-> (&wr_be_c)) else $error("R7"); // R7
  AST_BYTE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (size_c == ACC_BYTE) |-> !misalign_c) else $error("R8"); // R8

endmodule

// File: tb/test_lane_align_unit.sv
module test_lane_align_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  acc_size = 2'b00;
  logic [1:0]  byte_off = 2'b00;
  logic [31:0] rd_word = '0;
  logic [31:0] wr_src = '0;

  logic [31:0] ld_r, wl_r, ld_c, wl_c;
  logic [3:0]  be_r, be_c;
  logic        mis_r, mis_c;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 0;

  // Expected values queued when the stimulus is applied, compared one cycle later.
  logic [31:0] q_ld[$], q_wl[$];
  logic [3:0]  q_be[$];
  logic        q_mis[$];
  logic [1:0]  q_sz[$];

  always #10 clk = ~clk; // 50 MHz

  lane_align_unit i_lane_align_unit (
    .clk(clk), .rst_n(rst_n), .acc_size(acc_size), .byte_off(byte_off),
    .rd_word(rd_word), .wr_src(wr_src),
    .ld_result(ld_r), .wr_lanes(wl_r), .wr_be(be_r), .misalign(mis_r)
  );

  lane_align_unit #(.OUT_REG(1'b0)) i_lane_align_unit_comb (
    .clk(clk), .rst_n(rst_n), .acc_size(acc_size), .byte_off(byte_off),
    .rd_word(rd_word), .wr_src(wr_src),
    .ld_result(ld_c), .wr_lanes(wl_c), .wr_be(be_c), .misalign(mis_c)
  );

  function automatic logic [31:0] m_ld(input logic [1:0] sz, input logic [1:0] o, input logic [31:0] d);
    if (sz == 2'b00) return {24'h0, d[8*o +: 8]};                         // R4
    if (sz == 2'b01) return o[1] ? {16'h0, d[31:16]} : {16'h0, d[15:0]}; // R3
    return d;                                                             // R1 R2
  endfunction

  function automatic logic [31:0] m_wl(input logic [1:0] sz, input logic [31:0] s);
    if (sz == 2'b00) return {4{s[7:0]}};   // R6
    if (sz == 2'b01) return {2{s[15:0]}};  // R5
    return s;                               // R7
  endfunction

  function automatic logic [3:0] m_be(input logic [1:0] sz, input logic [1:0] o);
    if (sz == 2'b00) return 4'b0001 << o;                // R6
    if (sz == 2'b01) return o[1] ? 4'b1100 : 4'b0011;    // R5
    return 4'b1111;                                      // R7
  endfunction

  function automatic logic m_mis(input logic [1:0] sz, input logic [1:0] o);
    if (sz == 2'b00) return 1'b0;
    if (sz == 2'b01) return o[0];
    return o != 2'b00;                                   // R8
  endfunction

  function automatic string ld_tag(input logic [1:0] sz);
    if (sz == 2'b00) return "R4";
    if (sz == 2'b01) return "R3";
    return "R2 R1";
  endfunction

  function automatic string st_tag(input logic [1:0] sz);
    if (sz == 2'b00) return "R6";
    if (sz == 2'b01) return "R5";
    return "R7 R1";
  endfunction

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Called at a falling edge: both instances must reflect the oldest queued stimulus.
  task automatic check_pending();
    logic [1:0] sz;
    if (q_ld.size() == 0) return;
    sz = q_sz.pop_front();
    begin
      logic [31:0] eld, ewl; logic [3:0] ebe; logic emis;
      eld = q_ld.pop_front(); ewl = q_wl.pop_front();
      ebe = q_be.pop_front(); emis = q_mis.pop_front();
      cmp({ld_tag(sz), " R9 reg ld"}, ld_r, eld);
      cmp({st_tag(sz), " R9 reg lanes"}, wl_r, ewl);
      cmp({st_tag(sz), " R9 reg be"}, {28'h0, be_r}, {28'h0, ebe});
      cmp("R8 R9 reg misalign", {31'h0, mis_r}, {31'h0, emis});
      cmp({ld_tag(sz), " R9 comb ld"}, ld_c, eld);
      cmp({st_tag(sz), " R9 comb lanes"}, wl_c, ewl);
      cmp({st_tag(sz), " R9 comb be"}, {28'h0, be_c}, {28'h0, ebe});
      cmp("R8 R9 comb misalign", {31'h0, mis_c}, {31'h0, emis});
    end
  endtask

  task automatic apply(input logic [1:0] sz, input logic [1:0] o, input logic [31:0] d, input logic [31:0] s);
    @(negedge clk);
    check_pending();
    acc_size = sz; byte_off = o; rd_word = d; wr_src = s;
    q_sz.push_back(sz);
    q_ld.push_back(m_ld(sz, o, d));
    q_wl.push_back(m_wl(sz, s));
    q_be.push_back(m_be(sz, o));
    q_mis.push_back(m_mis(sz, o));
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    logic [31:0] lcg;
    lcg = 32'h1234_5678;
    // Reset: drive non-zero inputs; registered outputs must stay zero (R9).
    acc_size = 2'b10; byte_off = 2'b00; rd_word = 32'hDEAD_BEEF; wr_src = 32'hCAFE_F00D;
    repeat (3) @(negedge clk);
    cmp("R9 reset ld", ld_r, 32'h0);
    cmp("R9 reset lanes", wl_r, 32'h0);
    cmp("R9 reset be", {28'h0, be_r}, 32'h0);
    cmp("R9 reset misalign", {31'h0, mis_r}, 32'h0);
    rst_n = 1'b1;

    // Directed sweep: every size code and offset, two data patterns.
    for (int sz = 0; sz < 4; sz++)
      for (int o = 0; o < 4; o++) begin
        apply(2'(sz), 2'(o), 32'h4433_2211, 32'hA1B2_C3D4);
        apply(2'(sz), 2'(o), 32'h8877_FF66, 32'h0F1E_2D3C);
      end

    // Pseudo-random traffic.
    for (int k = 0; k < 400; k++) begin
      logic [31:0] d, s;
      lcg = lcg * 32'd1664525 + 32'd1013904223; d = lcg;
      lcg = lcg * 32'd1664525 + 32'd1013904223; s = lcg;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      apply(lcg[31:30], lcg[17:16], d, s);
    end

    @(negedge clk);
    check_pending();
    done = 1;
    finish_run();
  end

endmodule